// File: doc/BRIEF.md
# Command Packet Register Processor

This block sits at the control input of a processing block. It takes command packets from a 64-bit AXI-Stream. Each well-formed command turns into one write on a simple settings bus made of an address, a data word and a one-clock strobe. After each command the block returns exactly one two-beat response packet on a second AXI-Stream. Reads have no address of their own. Software first writes a readback-select register, and every later command is answered with the status word that is currently selected.

The block owns two of those selects. One picks a word from its own small status set: a block identifier, the flow-control window size, or zero. The other hands the choice to user logic and returns whatever arrives on `rb_data`. Two user addresses are also turned into single beats of a control-data stream. All other addresses pass through as strobes for registers outside the block.

Top module: `cpr_cmd_proc`

## Requirements
- R1: In the payload word, bits [39:32] are the register address and bits [31:0] are the write data. A well-formed command drives exactly these values on `set_addr` and `set_data` while `set_stb` is high.
- R2: `set_stb` is high for exactly one clock per well-formed command and is never high on two clocks in a row.
- R3: Every command packet, good or bad, produces exactly one response packet. The packet has two beats: the header first with tlast low, then the payload with tlast high.
- R4: The response header has this layout:
  - bits [63:62] are 2'b11 and bit 61 (time present) is 0;
  - bit 60 is 0 for a good command;
  - bits [59:48] copy the command's sequence number and bits [47:32] hold 16;
  - bits [31:16] carry the command's bits [15:0], and bits [15:0] carry the command's bits [31:16].
- R5: A command whose beat count is not exactly two (header plus one payload) is malformed. Its response has bit 60 set. It causes no strobe, no control beat and no change of readback selection.
- R6: A write to address 127 selects the block's own status word, indexed by the write data. Index 0 gives the BLOCK_ID parameter, index 1 gives WINDOW_SIZE, and any other index gives 0. The response payload carries this word in bits [31:0] with bits [63:32] zero, and this applies to the response of that same write.
- R7: A write to address 255 selects user readback. Response payloads then carry the value `rb_data` holds in the clock cycle right after the strobe.
- R8: A write to address 129 or 130 raises `ctl_tvalid` for one clock, in the same cycle as `set_stb`, with `ctl_tdata` equal to the write data. `ctl_tlast` is 0 for 129 and 1 for 130. No other address raises `ctl_tvalid`.
- R9: After reset the outputs `set_stb`, `ctl_tvalid` and `rsp_tvalid` are low, `cmd_tready` is high, and the selection is the block's own word at index 0.
- R10: While `rsp_tvalid` is high and `rsp_tready` is low, the response beat stays valid and unchanged.
- R11: No command beat is accepted while a response beat is being offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_tdata | input | 64 | Command stream data |
| cmd_tlast | input | 1 | Command stream end of packet |
| cmd_tvalid | input | 1 | Command stream valid |
| cmd_tready | output | 1 | Command stream ready |
| rsp_tdata | output | 64 | Response stream data |
| rsp_tlast | output | 1 | Response stream end of packet |
| rsp_tvalid | output | 1 | Response stream valid |
| rsp_tready | input | 1 | Response stream ready |
| set_addr | output | 8 | Settings bus address |
| set_data | output | 32 | Settings bus write data |
| set_stb | output | 1 | Settings bus write strobe |
| rb_data | input | 32 | User readback word |
| ctl_tdata | output | 32 | Control-data beat payload |
| ctl_tlast | output | 1 | Control-data beat end flag |
| ctl_tvalid | output | 1 | Control-data beat valid |

## Verification
Plain writes to ordinary addresses check the address and data split and the header swap. A mix of sequence numbers and stream IDs in the headers shows that fields are not crossed. A series of writes to the two select registers, with indices 0, 1 and one out of range, separates the block-word mux from the user path. It also shows that the response to a select write already carries the new word. One-beat and three-beat commands show that malformed packets report an error and leave both the strobe and the selection alone. Running the same traffic with a stalling response sink separates correct beat holding from beats that are dropped or repeated.

// File: rtl/cpr_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the command packet register processor.
// Assumes a 64-bit packet word with the header laid out as pkt_hdr_t.
package cpr_pkg;

    localparam int STREAM_W = 64;

    typedef struct packed {
        logic [1:0]  kind;
        logic        has_time;
        logic        eob_err;
        logic [11:0] seq;
        logic [15:0] len_bytes;
        logic [15:0] src_sid;
        logic [15:0] dst_sid;
    } pkt_hdr_t;

    localparam logic [7:0]  ADDR_SHELL_RB = 8'd127;
    localparam logic [7:0]  ADDR_USER_RB  = 8'd255;
    localparam logic [7:0]  ADDR_CTL_MID  = 8'd129;
    localparam logic [7:0]  ADDR_CTL_END  = 8'd130;
    localparam logic [15:0] RSP_LEN_BYTES = 16'd16;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_PAY,
        ST_DRAIN,
        ST_STRB,
        ST_CAP,
        ST_WAIT
    } ing_state_t;

    // Build a response header from the command header and an error flag.
    function automatic pkt_hdr_t make_rsp_hdr(input pkt_hdr_t cmd, input logic err);
        pkt_hdr_t r;
        r.kind      = 2'b11;
        r.has_time  = 1'b0;
        r.eob_err   = err;
        r.seq       = cmd.seq;
        r.len_bytes = RSP_LEN_BYTES;
        r.src_sid   = cmd.dst_sid;
        r.dst_sid   = cmd.src_sid;
        return r;
    endfunction

endpackage

// File: rtl/cpr_ingest.sv
`timescale 1ns/1ps
// Command intake: accepts one packet at a time, checks its beat count,
// issues the settings-bus write and control beat, then hands over to the
// response side and waits for it to finish.
// Assumes the response side pulses resp_done on its final accepted beat.
module cpr_ingest
    import cpr_pkg::*;
#(
    parameter int REG_ADDR_W = 8,
    parameter int REG_DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [STREAM_W-1:0]   cmd_tdata,
    input  logic                  cmd_tlast,
    input  logic                  cmd_tvalid,
    output logic                  cmd_tready,
    input  logic                  resp_done,
    output logic [REG_ADDR_W-1:0] set_addr,
    output logic [REG_DATA_W-1:0] set_data,
    output logic                  set_stb,
    output logic [REG_DATA_W-1:0] ctl_tdata,
    output logic                  ctl_tlast,
    output logic                  ctl_tvalid,
    output logic                  resp_go,
    output pkt_hdr_t              cmd_hdr,
    output logic                  cmd_err
);

    ing_state_t            st;
    logic                  take;
    logic [REG_ADDR_W-1:0] pay_addr;
    logic [REG_DATA_W-1:0] pay_data;
    logic                  pay_is_ctl;

    // Ready only while a packet is being taken in.
    always_comb begin
        cmd_tready = (st == ST_HDR) || (st == ST_PAY) || (st == ST_DRAIN);
        take       = cmd_tready && cmd_tvalid;
        pay_addr   = cmd_tdata[REG_DATA_W +: REG_ADDR_W];
        pay_data   = cmd_tdata[REG_DATA_W-1:0];
        pay_is_ctl = (pay_addr == ADDR_CTL_MID) || (pay_addr == ADDR_CTL_END);
        resp_go    = (st == ST_CAP);
    end

    // Packet state machine, header capture and error tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_HDR;
            cmd_hdr <= '0;
            cmd_err <= 1'b0;
        end else begin
            case (st)
                ST_HDR: if (take) begin
                    cmd_hdr <= pkt_hdr_t'(cmd_tdata);
                    cmd_err <= cmd_tlast;
                    st      <= cmd_tlast ? ST_CAP : ST_PAY;
                end
                ST_PAY: if (take) begin
                    if (cmd_tlast) begin
                        st <= ST_STRB;
                    end else begin
                        cmd_err <= 1'b1;
                        st      <= ST_DRAIN;
                    end
                end
                ST_DRAIN: if (take && cmd_tlast) st <= ST_CAP;
                ST_STRB:  st <= ST_CAP;
                ST_CAP:   st <= ST_WAIT;
                ST_WAIT:  if (resp_done) st <= ST_HDR;
                default:  st <= ST_HDR;
            endcase
        end
    end

    // Settings-bus write and control beat for a well-formed payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_stb    <= 1'b0;
            set_addr   <= '0;
            set_data   <= '0;
            ctl_tvalid <= 1'b0;
            ctl_tlast  <= 1'b0;
            ctl_tdata  <= '0;
        end else begin
            set_stb    <= 1'b0;
            ctl_tvalid <= 1'b0;
            if (st == ST_PAY && take && cmd_tlast) begin
                set_stb    <= 1'b1;
                set_addr   <= pay_addr;
                set_data   <= pay_data;
                ctl_tvalid <= pay_is_ctl;
                ctl_tlast  <= (pay_addr == ADDR_CTL_END);
                ctl_tdata  <= pay_data;
            end
        end
    end

    p_stb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> !set_stb);

    p_ctl_with_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_tvalid |-> (set_stb && (set_addr == ADDR_CTL_MID || set_addr == ADDR_CTL_END)));

    p_err_no_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_go && cmd_err) |-> !set_stb);

endmodule

// File: rtl/cpr_rb_select.sv
`timescale 1ns/1ps
// Readback selection: keeps the select state written through addresses
// 127 and 255, and muxes the block's own status words or user readback.
// Assumes writes arrive as single-clock strobes on the settings bus.
module cpr_rb_select
    import cpr_pkg::*;
#(
    parameter int                  REG_ADDR_W  = 8,
    parameter int                  REG_DATA_W  = 32,
    parameter logic [REG_DATA_W-1:0] BLOCK_ID    = 32'h0000_C0DE,
    parameter logic [REG_DATA_W-1:0] WINDOW_SIZE = 32'd2048
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_stb,
    input  logic [REG_ADDR_W-1:0] set_addr,
    input  logic [REG_DATA_W-1:0] set_data,
    input  logic [REG_DATA_W-1:0] rb_data,
    output logic [REG_DATA_W-1:0] rb_word
);

    logic                  sel_user;
    logic [REG_DATA_W-1:0] shell_idx;
    logic [REG_DATA_W-1:0] shell_word;

    // Update the selection on writes to either select address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_user  <= 1'b0;
            shell_idx <= '0;
        end else if (set_stb) begin
            if (set_addr == ADDR_SHELL_RB) begin
                sel_user  <= 1'b0;
                shell_idx <= set_data;
            end else if (set_addr == ADDR_USER_RB) begin
                sel_user  <= 1'b1;
            end
        end
    end

    // Own status mux and final source choice.
    always_comb begin
        case (shell_idx)
            REG_DATA_W'(0): shell_word = BLOCK_ID;
            REG_DATA_W'(1): shell_word = WINDOW_SIZE;
            default:        shell_word = '0;
        endcase
        rb_word = sel_user ? rb_data : shell_word;
    end

    p_user_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb && set_addr == ADDR_USER_RB) |=> (rb_word == rb_data));

endmodule

// File: rtl/cpr_resp_tx.sv
`timescale 1ns/1ps
// Response emitter: on resp_go captures the response header and the
// selected readback word, then offers header and payload beats in order.
// Assumes resp_go is not raised again before resp_done.
module cpr_resp_tx
    import cpr_pkg::*;
#(
    parameter int REG_DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  resp_go,
    input  pkt_hdr_t              cmd_hdr,
    input  logic                  cmd_err,
    input  logic [REG_DATA_W-1:0] rb_word,
    output logic [STREAM_W-1:0]   rsp_tdata,
    output logic                  rsp_tlast,
    output logic                  rsp_tvalid,
    input  logic                  rsp_tready,
    output logic                  resp_done
);

    localparam int PAD_W = STREAM_W - REG_DATA_W;

    typedef enum logic [1:0] {PH_IDLE, PH_HEAD, PH_BODY} phase_t;

    phase_t                ph;
    pkt_hdr_t              hdr_q;
    logic [REG_DATA_W-1:0] word_q;

    // Beat sequencing and capture of header and readback word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= PH_IDLE;
            hdr_q  <= '0;
            word_q <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (resp_go) begin
                    hdr_q  <= make_rsp_hdr(cmd_hdr, cmd_err);
                    word_q <= rb_word;
                    ph     <= PH_HEAD;
                end
                PH_HEAD: if (rsp_tready) ph <= PH_BODY;
                PH_BODY: if (rsp_tready) ph <= PH_IDLE;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Output beat selection.
    always_comb begin
        rsp_tvalid = (ph != PH_IDLE);
        rsp_tlast  = (ph == PH_BODY);
        rsp_tdata  = (ph == PH_HEAD) ? STREAM_W'(hdr_q) : {{PAD_W{1'b0}}, word_q};
        resp_done  = (ph == PH_BODY) && rsp_tready;
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_tvalid && !rsp_tready) |=> (rsp_tvalid && $stable(rsp_tdata) && $stable(rsp_tlast)));

    p_hdr_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_tvalid && !rsp_tlast) |-> (rsp_tdata[63:61] == 3'b110 && rsp_tdata[47:32] == 16'd16));

    p_body_after_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_tvalid && !rsp_tlast && rsp_tready) |=> (rsp_tvalid && rsp_tlast));

endmodule

// File: rtl/cpr_cmd_proc.sv
`timescale 1ns/1ps
// Top level: command packets in, settings-bus writes and control beats
// out, one response packet back per command.
// Assumes a single command stream and one response consumer.
module cpr_cmd_proc
    import cpr_pkg::*;
#(
    parameter int                    REG_ADDR_W  = 8,
    parameter int                    REG_DATA_W  = 32,
    parameter logic [REG_DATA_W-1:0] BLOCK_ID    = 32'h0000_C0DE,
    parameter logic [REG_DATA_W-1:0] WINDOW_SIZE = 32'd2048
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [63:0]           cmd_tdata,
    input  logic                  cmd_tlast,
    input  logic                  cmd_tvalid,
    output logic                  cmd_tready,
    output logic [63:0]           rsp_tdata,
    output logic                  rsp_tlast,
    output logic                  rsp_tvalid,
    input  logic                  rsp_tready,
    output logic [REG_ADDR_W-1:0] set_addr,
    output logic [REG_DATA_W-1:0] set_data,
    output logic                  set_stb,
    input  logic [REG_DATA_W-1:0] rb_data,
    output logic [REG_DATA_W-1:0] ctl_tdata,
    output logic                  ctl_tlast,
    output logic                  ctl_tvalid
);

    logic                  resp_go;
    logic                  resp_done;
    logic                  cmd_err;
    pkt_hdr_t              cmd_hdr;
    logic [REG_DATA_W-1:0] rb_word;

    cpr_ingest #(
        .REG_ADDR_W (REG_ADDR_W),
        .REG_DATA_W (REG_DATA_W)
    ) u_ingest (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_tdata  (cmd_tdata),
        .cmd_tlast  (cmd_tlast),
        .cmd_tvalid (cmd_tvalid),
        .cmd_tready (cmd_tready),
        .resp_done  (resp_done),
        .set_addr   (set_addr),
        .set_data   (set_data),
        .set_stb    (set_stb),
        .ctl_tdata  (ctl_tdata),
        .ctl_tlast  (ctl_tlast),
        .ctl_tvalid (ctl_tvalid),
        .resp_go    (resp_go),
        .cmd_hdr    (cmd_hdr),
        .cmd_err    (cmd_err)
    );

    cpr_rb_select #(
        .REG_ADDR_W  (REG_ADDR_W),
        .REG_DATA_W  (REG_DATA_W),
        .BLOCK_ID    (BLOCK_ID),
        .WINDOW_SIZE (WINDOW_SIZE)
    ) u_rb_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_stb  (set_stb),
        .set_addr (set_addr),
        .set_data (set_data),
        .rb_data  (rb_data),
        .rb_word  (rb_word)
    );

    cpr_resp_tx #(
        .REG_DATA_W (REG_DATA_W)
    ) u_resp_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .resp_go    (resp_go),
        .cmd_hdr    (cmd_hdr),
        .cmd_err    (cmd_err),
        .rb_word    (rb_word),
        .rsp_tdata  (rsp_tdata),
        .rsp_tlast  (rsp_tlast),
        .rsp_tvalid (rsp_tvalid),
        .rsp_tready (rsp_tready),
        .resp_done  (resp_done)
    );

    p_one_at_a_time_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_tvalid |-> !cmd_tready);

endmodule

// File: tb/tb_cpr_cmd_proc.sv
`timescale 1ns/1ps
module tb_cpr_cmd_proc;

    localparam logic [31:0] BID = 32'h0000_C0DE;
    localparam logic [31:0] WIN = 32'd2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cmd_tdata = '0;
    logic        cmd_tlast = 1'b0;
    logic        cmd_tvalid = 1'b0;
    logic        cmd_tready;
    logic [63:0] rsp_tdata;
    logic        rsp_tlast;
    logic        rsp_tvalid;
    logic        rsp_tready = 1'b1;
    logic [7:0]  set_addr;
    logic [31:0] set_data;
    logic        set_stb;
    logic [31:0] rb_data;
    logic [31:0] ctl_tdata;
    logic        ctl_tlast;
    logic        ctl_tvalid;

    always #2 clk = ~clk;

    cpr_cmd_proc dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_tdata(cmd_tdata), .cmd_tlast(cmd_tlast), .cmd_tvalid(cmd_tvalid), .cmd_tready(cmd_tready),
        .rsp_tdata(rsp_tdata), .rsp_tlast(rsp_tlast), .rsp_tvalid(rsp_tvalid), .rsp_tready(rsp_tready),
        .set_addr(set_addr), .set_data(set_data), .set_stb(set_stb), .rb_data(rb_data),
        .ctl_tdata(ctl_tdata), .ctl_tlast(ctl_tlast), .ctl_tvalid(ctl_tvalid)
    );

    // Stand-in user logic: its readback word follows writes to address 255.
    logic [31:0] usr_reg;
    always @(posedge clk) begin
        if (!rst_n) usr_reg <= 32'd0;
        else if (set_stb && set_addr == 8'd255) usr_reg <= set_data;
    end
    assign rb_data = usr_reg ^ 32'hA5A5_0000;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Behavioural model state.
    bit          m_user = 0;
    logic [31:0] m_idx = 0;
    logic [31:0] m_usr = 0;
    logic [39:0] exp_stb[$];
    logic [32:0] exp_ctl[$];
    logic [39:0] obs_stb[$];
    logic [32:0] obs_ctl[$];
    logic [64:0] obs_rsp[$];

    // Response sink pattern.
    bit bp = 0;
    int cyc = 0;
    always @(posedge clk) begin
        #1;
        cyc++;
        rsp_tready = bp ? (cyc % 3 == 0) : 1'b1;
    end

    // Per-clock monitor.
    bit          prev_stb = 0;
    bit          stall_prev = 0;
    logic [64:0] stall_beat = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (set_stb) begin
                obs_stb.push_back({set_addr, set_data});
                check(!prev_stb, "R2 strobe one clock", 65'(prev_stb), 65'(0));
            end
            if (ctl_tvalid) begin
                obs_ctl.push_back({ctl_tlast, ctl_tdata});
                check(set_stb, "R8 ctl beat with strobe", 65'(set_stb), 65'(1));
            end
            if (stall_prev)
                check(rsp_tvalid && {rsp_tlast, rsp_tdata} == stall_beat, "R10 hold under stall",
                      {rsp_tlast, rsp_tdata}, stall_beat);
            if (rsp_tvalid && cmd_tready)
                check(0, "R11 accept during response", 65'(cmd_tready), 65'(0));
            if (rsp_tvalid && rsp_tready) obs_rsp.push_back({rsp_tlast, rsp_tdata});
            stall_prev = rsp_tvalid && !rsp_tready;
            stall_beat = {rsp_tlast, rsp_tdata};
            prev_stb   = set_stb;
        end
    end

    function automatic logic [31:0] exp_word();
        if (m_user) return m_usr ^ 32'hA5A5_0000;
        if (m_idx == 0) return BID;
        if (m_idx == 1) return WIN;
        return 32'd0;
    endfunction

    task automatic send_pkt(input logic [11:0] seq, input logic [15:0] src, input logic [15:0] dst,
                            input int nbeats, input logic [7:0] addr, input logic [31:0] data);
        logic [63:0] h;
        logic [63:0] eh;
        bit          good;
        h = {2'b10, 1'b0, 1'b0, seq, 16'(8 * nbeats), src, dst};
        for (int i = 0; i < nbeats; i++) begin
            @(negedge clk);
            cmd_tvalid = 1'b1;
            cmd_tdata  = (i == 0) ? h : ({24'd0, addr, data} + 64'(i - 1));
            cmd_tlast  = (i == nbeats - 1);
            while (!cmd_tready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        cmd_tvalid = 1'b0;
        cmd_tlast  = 1'b0;
        good = (nbeats == 2);
        if (good) begin
            exp_stb.push_back({addr, data});
            if (addr == 8'd129 || addr == 8'd130) exp_ctl.push_back({addr == 8'd130, data});
            if (addr == 8'd127) begin m_user = 0; m_idx = data; end
            if (addr == 8'd255) begin m_user = 1; m_usr = data; end
        end
        while (obs_rsp.size() < 2) @(negedge clk);
        repeat (3) @(negedge clk);
        eh = {2'b11, 1'b0, !good, seq, 16'd16, dst, src};
        check(obs_rsp.size() == 2, "R3 one two-beat response", 65'(obs_rsp.size()), 65'(2));
        check(obs_rsp[0] == {1'b0, eh}, good ? "R4 header" : "R5 error header", obs_rsp[0], {1'b0, eh});
        check(obs_rsp[1] == {1'b1, 32'd0, exp_word()}, "R6/R7 payload word R3 tlast",
              obs_rsp[1], {1'b1, 32'd0, exp_word()});
        check(obs_stb.size() == exp_stb.size(), good ? "R1 strobe count" : "R5 no strobe",
              65'(obs_stb.size()), 65'(exp_stb.size()));
        if (obs_stb.size() == 1 && exp_stb.size() == 1)
            check(obs_stb[0] == exp_stb[0], "R1 address and data", 65'(obs_stb[0]), 65'(exp_stb[0]));
        check(obs_ctl.size() == exp_ctl.size(), "R8 ctl beat count",
              65'(obs_ctl.size()), 65'(exp_ctl.size()));
        if (obs_ctl.size() == 1 && exp_ctl.size() == 1)
            check(obs_ctl[0] == exp_ctl[0], "R8 ctl beat value", 65'(obs_ctl[0]), 65'(exp_ctl[0]));
        obs_rsp.delete(); obs_stb.delete(); exp_stb.delete(); obs_ctl.delete(); exp_ctl.delete();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(!set_stb && !ctl_tvalid && !rsp_tvalid, "R9 outputs idle",
              65'({set_stb, ctl_tvalid, rsp_tvalid}), 65'(0));
        check(cmd_tready, "R9 ready after reset", 65'(cmd_tready), 65'(1));
        // R9 default selection, R1 plain write
        send_pkt(12'h001, 16'h0210, 16'h0300, 2, 8'h10, 32'h1234_5678);
        // R6 own status words
        send_pkt(12'h002, 16'h0211, 16'h0301, 2, 8'd127, 32'd1);
        send_pkt(12'hABC, 16'hBEEF, 16'h1234, 2, 8'd127, 32'd5);
        send_pkt(12'h004, 16'h0001, 16'hFFFF, 2, 8'd127, 32'd0);
        // R7 user readback
        send_pkt(12'h005, 16'h0A0B, 16'h0C0D, 2, 8'd255, 32'h0000_003C);
        send_pkt(12'hFFF, 16'h1111, 16'h2222, 2, 8'h80, 32'hDEAD_BEEF);
        // R8 control beats
        send_pkt(12'h007, 16'h0102, 16'h0304, 2, 8'd129, 32'hCAFE_0001);
        send_pkt(12'h008, 16'h0506, 16'h0708, 2, 8'd130, 32'hCAFE_0002);
        // R5 malformed: one beat and three beats aimed at the select register
        send_pkt(12'h009, 16'h0900, 16'h0A00, 1, 8'd127, 32'd1);
        send_pkt(12'h00A, 16'h0901, 16'h0A01, 3, 8'd127, 32'd1);
        send_pkt(12'h00B, 16'h0902, 16'h0A02, 2, 8'd131, 32'h0000_0055);
        // R10 response stalls
        bp = 1;
        send_pkt(12'h00C, 16'h7777, 16'h8888, 2, 8'd127, 32'd1);
        send_pkt(12'h00D, 16'h7778, 16'h8889, 2, 8'd255, 32'h0000_0099);
        send_pkt(12'h00E, 16'h777A, 16'h888A, 1, 8'd130, 32'd7);
        bp = 0;
        send_pkt(12'h00F, 16'h0F0F, 16'hF0F0, 2, 8'd127, 32'hFFFF_FFFF);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule